// File: doc/BRIEF.md
# Monitor Channel Byte Receiver

This block is the receiving end of the byte-wide monitor channel handshake on a time-multiplexed voice highway. Once per frame a frame strobe marks the moment when the downstream monitor byte and its active-low MX flag are valid. The receiver samples them and drives the upstream active-low MR flag for the next frame. A byte counts as received only when the same value is seen in two consecutive frames with MX active. The receiver acknowledges the byte by pulling MR low, and releases MR when the host lets MX go inactive.

Accepted bytes build a message in a fixed order: a device address, a command, a register address and then one or more data bytes. The device address is compared with a strapped local address. For each data byte the block emits a one-cycle write strobe together with the command, the register address and the data; the address advances by one for each further data byte. MX inactive for two consecutive frames marks the end of a message. A mismatch between the two looks at a byte, or MX going inactive straight after a first look, aborts the exchange. In that case MR stays inactive until the host has kept MX quiet for two frames.

Top module: `gci_mon_rx`

## Requirements
- R1: While reset is low and right after its release, mrOut is 1 and wrStb is 0. A reset in the middle of a message discards it, so the next accepted byte is treated as a device address.
- R2: A frame with mxIn=0 gives a first look at a byte. When the next frame also has mxIn=0 and the same monIn, the byte is accepted and mrOut goes to 0. mrOut stays 0 while the host repeats the byte and returns to 1 at the first frame with mxIn=1.
- R3: If the second look differs from the first, mrOut stays 1 and every later byte is ignored. Only two consecutive frames with mxIn=1 bring the receiver back to idle.
- R4: A frame with mxIn=1 straight after a first look aborts the byte. That frame counts as the first of the two quiet frames needed to return to idle.
- R5: If the first byte of a message is not equal to localAddr, it is not acknowledged. The rest of the message is then ignored, with mrOut held at 1, until two consecutive frames with mxIn=1.
- R6: Bytes are taken in this order: device address, command, register address, data. Each accepted data byte gives wrStb=1 for exactly one clock, in the clock after the frame strobe that accepts it. With the pulse come wrCmd (the command byte), wrData (the data byte) and wrAddr, which is the register address plus the index of the data byte (0 for the first).
- R7: Two consecutive frames with mxIn=1 after an acknowledged byte end the message. If this happens before any data byte has been accepted, no write strobe is issued.
- R8: When an accepted byte is repeated in further frames, no additional write is issued.
- R9: After a message ends or an abort completes, the next accepted byte is again a device address, and the register address is taken from the new message.
- R10: mrOut changes only in the clock after a frame strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStb | input | 1 | One-clock pulse marking the monitor sample point of a frame |
| mxIn | input | 1 | Downstream MX flag, 0 = active |
| monIn | input | BYTE_W | Downstream monitor byte |
| localAddr | input | BYTE_W | Device address this receiver answers to |
| mrOut | output | 1 | Upstream MR acknowledge, 0 = active |
| wrStb | output | 1 | One-clock register write strobe |
| wrCmd | output | BYTE_W | Command byte of the current message |
| wrAddr | output | BYTE_W | Register address of this write |
| wrData | output | BYTE_W | Data byte to write |

## Verification
A wrong control state shows up on mrOut one frame later: an ack that is missing or arrives early, or MR held low during an abort. The host would see a stalled or broken handshake in the very next frame. A wrong sequence index or register base shows only at wrStb, one clock after the data byte is accepted. Either the strobe is missing, or it carries the wrong address or command, which would corrupt a register. For this reason, the checks cover mrOut in every frame and the complete write tuple on every data byte, both across message boundaries and after aborts.

// File: rtl/gci_mon_rx_pkg.sv
package gci_mon_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_ACKED,
    ST_GAP,
    ST_ABORT,
    ST_IGNORE
  } rxState_t;

  typedef struct packed {
    logic loadCand;
    logic acceptByte;
    logic clrMsg;
  } rxStrobes_t;

endpackage

// File: rtl/gci_mon_rx_ctrl.sv
module gci_mon_rx_ctrl
  import gci_mon_rx_pkg::*;
#(
  parameter int QUIET_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStb,
  input  logic       mxIn,
  input  logic       candMatch,
  input  logic       addrMatch,
  input  logic       atAddrByte,
  output rxStrobes_t strobes,
  output logic       mrOut
);

  localparam int CNT_W = $clog2(QUIET_FRAMES + 1);
  localparam logic [CNT_W-1:0] QUIET_LAST = CNT_W'(QUIET_FRAMES - 1);

  rxState_t   state;
  logic [CNT_W-1:0] quietCnt;
  logic       addrReject;
  logic       quietDone;
  logic       inQuietWait;

  assign addrReject  = atAddrByte && !addrMatch;
  assign quietDone   = mxIn && (quietCnt == QUIET_LAST);
  assign inQuietWait = (state == ST_GAP) || (state == ST_ABORT) || (state == ST_IGNORE);

  always_comb begin
    strobes = '0;
    if (frameStb) begin
      strobes.loadCand   = !mxIn && ((state == ST_IDLE) || (state == ST_GAP));
      strobes.acceptByte = (state == ST_FIRST) && !mxIn && candMatch && !addrReject;
      strobes.clrMsg     = inQuietWait && quietDone;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      mrOut    <= 1'b1;
      quietCnt <= '0;
    end else if (frameStb) begin
      case (state)
        ST_IDLE: begin
          if (!mxIn) state <= ST_FIRST;
        end
        ST_FIRST: begin
          if (!mxIn && candMatch) begin
            if (addrReject) begin
              state    <= ST_IGNORE;
              quietCnt <= '0;
            end else begin
              state <= ST_ACKED;
              mrOut <= 1'b0;
            end
          end else begin
            state    <= ST_ABORT;
            quietCnt <= mxIn ? CNT_W'(1) : '0;
          end
        end
        ST_ACKED: begin
          if (mxIn) begin
            state    <= ST_GAP;
            mrOut    <= 1'b1;
            quietCnt <= CNT_W'(1);
          end else if (!candMatch) begin
            state    <= ST_ABORT;
            mrOut    <= 1'b1;
            quietCnt <= '0;
          end
        end
        ST_GAP: begin
          if (!mxIn)          state <= ST_FIRST;
          else if (quietDone) state <= ST_IDLE;
          else                quietCnt <= quietCnt + 1'b1;
        end
        default: begin
          if (!mxIn)          quietCnt <= '0;
          else if (quietDone) state <= ST_IDLE;
          else                quietCnt <= quietCnt + 1'b1;
        end
      endcase
    end
  end

  // R3
  abort_mr_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ABORT) || (state == ST_IGNORE)) |-> mrOut);

  // R2
  acked_mr_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACKED) |-> !mrOut);

  // R10
  mr_frame_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mrOut) |-> $past(frameStb));

endmodule

// File: rtl/gci_mon_rx_dpath.sv
module gci_mon_rx_dpath
  import gci_mon_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int HDR_BYTES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] monIn,
  input  logic [BYTE_W-1:0] localAddr,
  input  rxStrobes_t        strobes,
  output logic              candMatch,
  output logic              addrMatch,
  output logic              atAddrByte,
  output logic              wrStb,
  output logic [BYTE_W-1:0] wrCmd,
  output logic [BYTE_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData
);

  localparam int SEQ_W = $clog2(HDR_BYTES + 1);
  localparam logic [SEQ_W-1:0] SEQ_CMD  = SEQ_W'(1);
  localparam logic [SEQ_W-1:0] SEQ_REG  = SEQ_W'(2);
  localparam logic [SEQ_W-1:0] SEQ_DATA = SEQ_W'(HDR_BYTES);

  logic [BYTE_W-1:0] candByte;
  logic [BYTE_W-1:0] cmdReg;
  logic [BYTE_W-1:0] regBase;
  logic [BYTE_W-1:0] dataOfs;
  logic [SEQ_W-1:0]  seqIdx;

  assign candMatch  = (monIn == candByte);
  assign addrMatch  = (monIn == localAddr);
  assign atAddrByte = (seqIdx == '0);
  assign wrCmd      = cmdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candByte <= '0;
      cmdReg   <= '0;
      regBase  <= '0;
      dataOfs  <= '0;
      seqIdx   <= '0;
      wrStb    <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
    end else begin
      wrStb <= 1'b0;
      if (strobes.loadCand) candByte <= monIn;
      if (strobes.clrMsg) begin
        seqIdx <= '0;
      end else if (strobes.acceptByte) begin
        if (seqIdx != SEQ_DATA) seqIdx <= seqIdx + 1'b1;
        if (seqIdx == SEQ_CMD) cmdReg <= monIn;
        if (seqIdx == SEQ_REG) begin
          regBase <= monIn;
          dataOfs <= '0;
        end
        if (seqIdx == SEQ_DATA) begin
          wrStb   <= 1'b1;
          wrData  <= monIn;
          wrAddr  <= regBase + dataOfs;
          dataOfs <= dataOfs + 1'b1;
        end
      end
    end
  end

  // R6
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb);

  // R6
  wr_data_from_cand_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> (wrData == candByte));

endmodule

// File: rtl/gci_mon_rx.sv
module gci_mon_rx
  import gci_mon_rx_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int HDR_BYTES    = 3,
  parameter int QUIET_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStb,
  input  logic              mxIn,
  input  logic [BYTE_W-1:0] monIn,
  input  logic [BYTE_W-1:0] localAddr,
  output logic              mrOut,
  output logic              wrStb,
  output logic [BYTE_W-1:0] wrCmd,
  output logic [BYTE_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData
);

  rxStrobes_t strobes;
  logic       candMatch;
  logic       addrMatch;
  logic       atAddrByte;

  gci_mon_rx_ctrl #(
    .QUIET_FRAMES(QUIET_FRAMES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStb  (frameStb),
    .mxIn      (mxIn),
    .candMatch (candMatch),
    .addrMatch (addrMatch),
    .atAddrByte(atAddrByte),
    .strobes   (strobes),
    .mrOut     (mrOut)
  );

  gci_mon_rx_dpath #(
    .BYTE_W   (BYTE_W),
    .HDR_BYTES(HDR_BYTES)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .monIn     (monIn),
    .localAddr (localAddr),
    .strobes   (strobes),
    .candMatch (candMatch),
    .addrMatch (addrMatch),
    .atAddrByte(atAddrByte),
    .wrStb     (wrStb),
    .wrCmd     (wrCmd),
    .wrAddr    (wrAddr),
    .wrData    (wrData)
  );

  // R6
  wr_on_active_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> ($past(frameStb) && !$past(mxIn)));

endmodule

// File: tb/tb_gci_mon_rx.sv
module tb_gci_mon_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStb = 1'b0;
  logic       mxIn = 1'b1;
  logic [7:0] monIn = 8'h00;
  logic [7:0] localAddr = 8'h5A;
  logic       mrOut;
  logic       wrStb;
  logic [7:0] wrCmd;
  logic [7:0] wrAddr;
  logic [7:0] wrData;

  int checks = 0;
  int failures = 0;
  logic sMr, sWr;
  logic [7:0] sCmd, sAddr, sData;

  always #4 clk = ~clk;

  gci_mon_rx dut (
    .clk(clk), .rstN(rstN), .frameStb(frameStb), .mxIn(mxIn), .monIn(monIn),
    .localAddr(localAddr), .mrOut(mrOut), .wrStb(wrStb), .wrCmd(wrCmd),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  typedef struct packed {
    logic       mx;
    logic [7:0] mon;
    logic       expMr;
    logic       expWr;
    logic [7:0] expCmd;
    logic [7:0] expAddr;
    logic [7:0] expData;
  } vec_t;

  localparam int NVEC = 56;
  localparam vec_t VEC [NVEC] = '{
    // R2 R6 R8 R7: full message, two data bytes
    '{1'b0, 8'h5A, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h5A, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h81, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h81, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h10, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h10, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'hC3, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'hC3, 1'b0, 1'b1, 8'h81, 8'h10, 8'hC3},
    '{1'b0, 8'hC3, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h3C, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h3C, 1'b0, 1'b1, 8'h81, 8'h11, 8'h3C},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    // R7: early end of message, no write
    '{1'b0, 8'h5A, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h5A, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h82, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h82, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    // R3: look mismatch aborts, bytes ignored until two quiet frames
    '{1'b0, 8'h5A, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h5B, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h5A, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h5A, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    // R5: foreign device address, whole message ignored
    '{1'b0, 8'h77, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h77, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h81, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h81, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h20, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h20, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'hC3, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'hC3, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    // R9: fresh message after aborts uses its own header
    '{1'b0, 8'h5A, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h5A, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h84, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h84, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h40, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h40, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h99, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 8'h99, 1'b0, 1'b1, 8'h84, 8'h40, 8'h99},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doFrame(input logic mx, input logic [7:0] b);
    @(negedge clk);
    mxIn = mx; monIn = b; frameStb = 1'b1;
    @(negedge clk);
    frameStb = 1'b0;
    sMr = mrOut; sWr = wrStb; sCmd = wrCmd; sAddr = wrAddr; sData = wrData;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 mr in reset", {7'd0, mrOut}, 8'h01);
    check("R1 wr in reset", {7'd0, wrStb}, 8'h00);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 mr after reset", {7'd0, mrOut}, 8'h01);

    for (int i = 0; i < NVEC; i++) begin
      doFrame(VEC[i].mx, VEC[i].mon);
      check("R2 mr per frame", {7'd0, sMr}, {7'd0, VEC[i].expMr});
      check("R6 wr strobe", {7'd0, sWr}, {7'd0, VEC[i].expWr});
      if (VEC[i].expWr) begin
        check("R6 wr cmd", sCmd, VEC[i].expCmd);
        check("R6 wr addr", sAddr, VEC[i].expAddr);
        check("R6 wr data", sData, VEC[i].expData);
      end
    end

    // R1: reset in the middle of a message discards it
    doFrame(1'b0, 8'h5A);
    doFrame(1'b0, 8'h5A);
    check("R1 ack before reset", {7'd0, sMr}, 8'h00);
    @(negedge clk); rstN = 1'b0;
    #1 check("R1 mr async reset", {7'd0, mrOut}, 8'h01);
    @(negedge clk); rstN = 1'b1;
    doFrame(1'b0, 8'hC3);
    doFrame(1'b0, 8'hC3);
    check("R1 restart at address byte", {7'd0, sMr}, 8'h01);
    check("R1 no write after reset", {7'd0, sWr}, 8'h00);
    doFrame(1'b1, 8'h00);
    doFrame(1'b1, 8'h00);

    // R4: MX inactive after first look aborts and counts as a quiet frame
    doFrame(1'b0, 8'h5A);
    doFrame(1'b1, 8'h00);
    check("R4 mr after early release", {7'd0, sMr}, 8'h01);
    doFrame(1'b1, 8'h00);
    doFrame(1'b0, 8'h5A);
    doFrame(1'b0, 8'h5A);
    check("R4 idle after one more quiet frame", {7'd0, sMr}, 8'h00);

    // R10: mr holds without a frame strobe
    @(negedge clk); mxIn = 1'b1; monIn = 8'hFF;
    repeat (6) @(negedge clk);
    check("R10 mr held between frames", {7'd0, mrOut}, 8'h00);
    doFrame(1'b1, 8'h00);
    check("R10 mr released at frame", {7'd0, sMr}, 8'h01);
    doFrame(1'b1, 8'h00);
    // R7: message ended after address only, nothing written
    check("R7 no write on short message", {7'd0, sWr}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule